// File: doc/BRIEF.md
# Three-Stage Programmable Clock Prescaler

This block turns a fast reference clock into a periodic one-cycle timing strobe for a slow serial bus. The division ratio is the product of three cascaded stages: a fixed divide by four, a linear divide by one plus an 8-bit timing value, and a power-of-two divide selected by a 3-bit exponent. With a timing value x and an exponent y, one strobe appears every 4 × (x+1) × 2^y reference cycles. For a bus rate between roughly 2 kHz and 2 MHz, with 1 MHz as the usual setting, the caller picks x and y. The block itself does not search for the best pair.

Settings are latched into an active copy only at a strobe, or at any time while the prescaler is stopped. A change made in the middle of a period therefore never shortens or stretches that period. While the run input is low, every stage counter sits at zero and both outputs stay low. An optional square-wave output can be built in. It is low for the first half of each period and high for the second half. To produce it, the fixed /4 stage is split into a /2 before the linear stage and a /2 after the exponent stage.

Top module: `ps_prescaler3`

## Requirements
- R1: While running, consecutive `tick` pulses are exactly 4 × (`div_lin`+1) × 2^`div_exp` reference cycles apart, using the latched settings.
- R2: `tick` is high for exactly one reference cycle per period and is low in the cycle after every pulse.
- R3: While `run_en` is low, `tick` and `sq_out` are low and all stage counters are held at zero. After `run_en` rises, the first `tick` comes a full period later, counting from the first enabled cycle.
- R4: A change of `div_lin` or `div_exp` while running does not alter the period in progress. The new ratio applies from the period that starts after the next `tick`.
- R5: With the square output built in, `sq_out` is low during the first half of each period and high during the second half, so it changes level every half period.
- R6: The extreme settings work. `div_lin`=0 with `div_exp`=0 gives a period of 4. `div_lin`=255 with `div_exp`=0, and `div_lin`=1 with `div_exp`=7, each give a period of 1024.
- R7: The settings present on the last clock edge at which `run_en` was sampled low set the length of the first period after enabling.
- R8: During reset and right after it is released, `tick` and `sq_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Prescaler run enable; low holds the counters at zero |
| div_lin | input | TVAL_W (8) | Linear stage timing value x, divides by x+1 |
| div_exp | input | EXP_W (3) | Exponent y, divides by 2^y |
| tick | output | 1 | One-cycle strobe at the divided rate |
| sq_out | output | 1 | Half-period square wave; tied low when not built in |

## Verification
A settings reload and the terminal strobe happen in the same cycle. A new ratio is driven immediately after a tick, and again a few cycles into a period. The bench then measures that the current period keeps its old length and the following one takes the new length. A stop request can also coincide with the counters mid-count. Its effect is judged by the absence of strobes and square-wave highs while stopped, and by a full-length first period after restarting. A behavioural cycle counter in the bench predicts `tick` and `sq_out` on every clock throughout.

// File: rtl/ps_prescaler3_pkg.sv
package ps_prescaler3_pkg;

   // counter width needed to hold 2^y - 1 for every exponent of the given width
   function automatic int unsigned exp_cnt_width(input int unsigned exp_w);
      return (1 << exp_w) - 1;
   endfunction

   // width of the fixed stage placed ahead of the linear stage
   function automatic int unsigned pre_width(input int unsigned fix_log2,
                                             input bit square_en);
      return square_en ? fix_log2 - 1 : fix_log2;
   endfunction

endpackage

// File: rtl/ps_mod_counter.sv
module ps_mod_counter #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] term,
   output logic [W-1:0] cnt,
   output logic         carry
);

   logic at_term;

   assign at_term = (cnt == term);
   assign carry   = adv & at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= at_term ? '0 : cnt + W'(1);
      end
   end

   // a cleared stage reads zero on the following cycle
   assert_clear_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // the count never passes its terminal value, so no period is lengthened
   assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term);

endmodule

// File: rtl/ps_exp_mask.sv
module ps_exp_mask #(
   parameter int unsigned EXP_W = 3,
   parameter int unsigned CNT_W = 7
) (
   input  logic [EXP_W-1:0] exp_in,
   output logic [CNT_W-1:0] mask
);

   for (genvar i = 0; i < CNT_W; i++) begin : g_bit
      assign mask[i] = (i < int'(exp_in));
   end

endmodule

// File: rtl/ps_settings.sv
module ps_settings #(
   parameter int unsigned TVAL_W = 8,
   parameter int unsigned EXP_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TVAL_W-1:0] x_in,
   input  logic [EXP_W-1:0]  y_in,
   output logic [TVAL_W-1:0] x_act,
   output logic [EXP_W-1:0]  y_act
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_act <= '0;
         y_act <= '0;
      end else if (load) begin
         x_act <= x_in;
         y_act <= y_in;
      end
   end

endmodule

// File: rtl/ps_prescaler3.sv
module ps_prescaler3
   import ps_prescaler3_pkg::*;
#(
   parameter int unsigned TVAL_W    = 8,
   parameter int unsigned EXP_W     = 3,
   parameter int unsigned FIX_LOG2  = 2,
   parameter bit          SQUARE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [TVAL_W-1:0] div_lin,
   input  logic [EXP_W-1:0]  div_exp,
   output logic              tick,
   output logic              sq_out
);

   localparam int unsigned EXP_CNT_W = exp_cnt_width(EXP_W);
   localparam int unsigned PRE_W     = pre_width(FIX_LOG2, SQUARE_EN);

   if (TVAL_W < 1 || TVAL_W > 16) begin : g_bad_tval
      $error("ps_prescaler3: TVAL_W must lie in 1..16");
   end
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("ps_prescaler3: EXP_W must lie in 1..5");
   end
   if (PRE_W < 1) begin : g_bad_fix
      $error("ps_prescaler3: FIX_LOG2 too small for the chosen variant");
   end

   logic [TVAL_W-1:0]    x_act;
   logic [EXP_W-1:0]     y_act;
   logic [EXP_CNT_W-1:0] exp_mask;
   logic [PRE_W-1:0]     pre_cnt;
   logic [TVAL_W-1:0]    lin_cnt;
   logic [EXP_CNT_W-1:0] exp_cnt;
   logic                 pre_carry;
   logic                 lin_carry;
   logic                 exp_carry;
   logic                 hold;

   assign hold = ~run_en;

   ps_settings #(.TVAL_W(TVAL_W), .EXP_W(EXP_W)) u_settings (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hold | tick),
      .x_in  (div_lin),
      .y_in  (div_exp),
      .x_act (x_act),
      .y_act (y_act)
   );

   ps_exp_mask #(.EXP_W(EXP_W), .CNT_W(EXP_CNT_W)) u_mask (
      .exp_in (y_act),
      .mask   (exp_mask)
   );

   // fixed stage ahead of the linear stage
   ps_mod_counter #(.W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hold),
      .adv   (run_en),
      .term  ({PRE_W{1'b1}}),
      .cnt   (pre_cnt),
      .carry (pre_carry)
   );

   ps_mod_counter #(.W(TVAL_W)) u_lin (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hold),
      .adv   (pre_carry),
      .term  (x_act),
      .cnt   (lin_cnt),
      .carry (lin_carry)
   );

   ps_mod_counter #(.W(EXP_CNT_W)) u_exp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hold),
      .adv   (lin_carry),
      .term  (exp_mask),
      .cnt   (exp_cnt),
      .carry (exp_carry)
   );

   if (SQUARE_EN) begin : g_square
      logic [0:0] half_cnt;
      logic       half_carry;

      // trailing /2 of the fixed stage; its state is the square wave
      ps_mod_counter #(.W(1)) u_post (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (hold),
         .adv   (exp_carry),
         .term  (1'b1),
         .cnt   (half_cnt),
         .carry (half_carry)
      );

      assign tick   = half_carry;
      assign sq_out = half_cnt[0];

      assert_sq_clears_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !sq_out);

      assert_sq_low_when_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !run_en |=> !sq_out);
   end else begin : g_plain
      assign tick   = exp_carry;
      assign sq_out = 1'b0;
   end

   assert_one_cycle_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   assert_settings_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !tick) |=> ($stable(x_act) && $stable(y_act)));

   assert_held_stages_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (lin_cnt == '0 && exp_cnt == '0 && pre_cnt == '0));

endmodule

// File: tb/ps_prescaler3_bench.sv
`timescale 1ns/1ps
module ps_prescaler3_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       run_en;
   logic [7:0] dx;
   logic [2:0] dy;
   logic       tick;
   logic       sq_out;

   int    checks = 0;
   int    errors = 0;
   string tag    = "R8";

   int mn = 0;
   int ax = 0;
   int ay = 0;

   always #2 clk = ~clk;

   ps_prescaler3 u_ps_prescaler3 (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .div_lin (dx),
      .div_exp (dy),
      .tick    (tick),
      .sq_out  (sq_out)
   );

   function automatic int period_of(input int x, input int y);
      return 4 * (x + 1) * (1 << y);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
      end
   endtask

   // behavioural reference: a single enabled-cycle count within the period
   always @(posedge clk) begin
      if (!rst_n) begin
         mn = 0; ax = 0; ay = 0;
      end else if (!run_en) begin
         mn = 0; ax = int'(dx); ay = int'(dy);
      end else if (mn == period_of(ax, ay) - 1) begin
         mn = 0; ax = int'(dx); ay = int'(dy);
      end else begin
         mn = mn + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         automatic int  p     = period_of(ax, ay);
         automatic bit  exp_t = run_en && (mn == p - 1);
         automatic bit  exp_s = run_en && (mn >= p / 2);
         chk(tick == exp_t, tag, int'(tick), int'(exp_t));
         chk(sq_out == exp_s, "R5", int'(sq_out), int'(exp_s));
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // counts negedges up to and including the next tick
   task automatic measure(input int exp_len, input string req);
      int c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!tick && c < 200000);
      chk(c == exp_len, req, c, exp_len);
   endtask

   task automatic drive_step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; run_en = 1'b0; dx = 8'd3; dy = 3'd1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(tick == 1'b0, "R8", int'(tick), 0);
      chk(sq_out == 1'b0, "R8", int'(sq_out), 0);
      drive_step();
      rst_n = 1'b1;
      @(negedge clk);
      chk(tick == 1'b0, "R8", int'(tick), 0);

      // stopped: nothing comes out
      tag = "R3";
      repeat (6) @(negedge clk);

      // start with x=3, y=1 -> 32
      drive_step();
      run_en = 1'b1;
      tag = "R7";
      measure(32, "R7");
      tag = "R1";
      measure(32, "R1");
      @(negedge clk);
      chk(tick == 1'b0, "R2", int'(tick), 0);
      measure(31, "R1");

      // change right after a tick: old period completes first
      drive_step();
      dx = 8'd0; dy = 3'd0;
      tag = "R4";
      measure(32, "R4");
      tag = "R6";
      measure(4, "R6");
      measure(4, "R6");

      drive_step();
      dx = 8'd0; dy = 3'd2;
      tag = "R4";
      measure(4, "R4");
      tag = "R6";
      measure(16, "R6");

      // change mid-period
      repeat (5) @(posedge clk);
      #1;
      dx = 8'd5; dy = 3'd1;
      tag = "R4";
      measure(12, "R4");
      tag = "R1";
      measure(48, "R1");

      // stop mid-period, then restart with a full period
      repeat (7) @(posedge clk);
      #1;
      run_en = 1'b0;
      tag = "R3";
      repeat (6) begin
         @(negedge clk);
         chk(tick == 1'b0, "R3", int'(tick), 0);
         chk(sq_out == 1'b0, "R3", int'(sq_out), 0);
      end
      drive_step();
      run_en = 1'b1;
      measure(48, "R3");

      // settings changed while stopped apply to the first period
      drive_step();
      run_en = 1'b0;
      drive_step();
      dx = 8'd255; dy = 3'd0;
      drive_step();
      run_en = 1'b1;
      tag = "R7";
      measure(1024, "R7");
      tag = "R6";
      measure(1024, "R6");

      drive_step();
      run_en = 1'b0; dx = 8'd1; dy = 3'd7;
      drive_step();
      run_en = 1'b1;
      measure(1024, "R6");

      // square wave shape over a period of 8
      drive_step();
      run_en = 1'b0; dx = 8'd1; dy = 3'd0;
      drive_step();
      run_en = 1'b1;
      tag = "R7";
      measure(8, "R7");
      tag = "R5";
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(sq_out == (i >= 4), "R5", int'(sq_out), int'(i >= 4));
      end

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule